// File: doc/BRIEF.md
# Configurable asynchronous serial framer

This block holds the bit-level machinery of an asynchronous serial port. One engine turns a parallel character into a line frame, and a second engine recovers characters from an incoming line. Both run from one shared baud timer. The timer divides the system clock by a 16-bit divisor. An optional fixed divide-by-4 stage can sit ahead of the divisor. The timer emits one oversampling tick per period, and sixteen ticks make one bit time.

The line settings are static inputs. Software must change them only while both engines are idle:

- character length: 5 to 8 bits;
- parity: none, even or odd;
- stop length: short or long.

The transmitter accepts a character with a one-cycle start pulse whenever it is not busy. It can also hold the line low on demand to send a break. The receiver synchronises the line and looks for a start bit, which it confirms at the middle of the bit. It delivers each character with a one-cycle valid pulse, together with parity-error, framing-error and break flags.

A loopback input routes the transmitter into the receiver internally. In loopback the external line input is ignored and the external line output is held at the idle level.

Top module: `serial_framer`

## Requirements
- R1: The oversampling tick period is max(baud_div,1) clocks, multiplied by 4 when baud_pre4 is 1; one bit lasts 16 ticks.
- R2: A frame has the following shape, on both the transmit line and the receive line:
  - a low start bit;
  - then 5+char_len data bits (char_len 0..3), least significant bit first;
  - the line idles high.
- R3: parity_mode[1]=1 inserts one parity bit after the data, where parity_mode[0]=0 selects even parity (parity bit = XOR of the data bits) and parity_mode[0]=1 selects odd parity (the inverse). The receiver compares the received parity bit with the value computed over its received data and raises rx_parity_err on a mismatch.
- R4: The stop period is 16 ticks when stop_long=0. When stop_long=1 it is 24 ticks with 5-bit characters and 32 ticks otherwise.
- R5: tx_start is taken only while tx_busy is low; a pulse while busy changes neither the frame in flight nor what follows it.
- R6: While tx_break is high, tx_line is low from the next clock on, whatever the transmitter state.
- R7: The receiver samples each bit at the 8th tick after start detection. A start whose middle sample is high is dropped, and no character is produced for it.
- R8: At the middle of the first stop bit, rx_valid pulses for one cycle with rx_data (upper unused bits zero) and rx_frame_err set if that sample is low. After a low stop sample, the receiver waits for the line to go high before it looks for a new start.
- R9: If every sample from start through the first stop bit is low, the receiver delivers rx_data=0 with rx_break=1, rx_frame_err=1 and rx_parity_err=0, and it produces nothing more until the line returns high.
- R10: With loopback=1 the receiver takes the transmitter's internal output, rx_line is ignored and tx_line stays high.
- R11: After reset tx_line is high, tx_busy is low and rx_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_div | input | DIV_W | Baud divisor (0 acts as 1) |
| baud_pre4 | input | 1 | Enables the divide-by-4 stage ahead of the divisor |
| char_len | input | 2 | Data bits minus 5 |
| parity_mode | input | 2 | [1] parity enable, [0] odd select |
| stop_long | input | 1 | Long stop period (1.5 or 2 bits) |
| loopback | input | 1 | Internal transmit-to-receive path |
| tx_start | input | 1 | Load tx_data and begin a frame when idle |
| tx_data | input | 8 | Character to send |
| tx_break | input | 1 | Force the transmit line low |
| tx_busy | output | 1 | Transmitter is sending a frame |
| tx_line | output | 1 | Serial transmit line |
| rx_line | input | 1 | Serial receive line (asynchronous) |
| rx_valid | output | 1 | One-cycle pulse: received character ready |
| rx_data | output | 8 | Received character |
| rx_parity_err | output | 1 | Parity mismatch on this character |
| rx_frame_err | output | 1 | First stop bit sampled low |
| rx_break | output | 1 | Whole character time low |

## Verification
The bench keeps the default DIV_W=16 and PRE_FACTOR=4. It programs divisors from 0 to 3, with and without the prescaler, which gives bit times of 16 to 192 clocks. At these rates a few hundred frames fit in the run, and the exact bit and stop-length durations can be counted clock by clock. These short periods also make false starts, framing errors and sustained breaks cheap to drive directly on the receive line. They also let random character lengths, parities and stop settings be checked against an independent line decoder.

// File: rtl/framer_pkg.sv
package framer_pkg;

    localparam int OVERSAMPLE = 16;
    localparam int MID_SAMPLE = 7;
    localparam int TICK_W     = 6;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP,
        PH_HOLD
    } phase_t;

    typedef struct packed {
        logic [1:0] len_code;
        logic       par_en;
        logic       par_odd;
        logic       stop_long;
    } frame_cfg_t;

    function automatic logic [2:0] last_bit_idx(input logic [1:0] len_code);
        return 3'd4 + {1'b0, len_code};
    endfunction

    function automatic logic [7:0] len_mask(input logic [1:0] len_code);
        return 8'hFF >> (2'd3 - len_code);
    endfunction

    function automatic logic parity_bit(input logic [7:0] d, input logic [1:0] len_code,
                                        input logic odd);
        return (^(d & len_mask(len_code))) ^ odd;
    endfunction

    function automatic logic [TICK_W-1:0] stop_ticks(input frame_cfg_t c);
        if (!c.stop_long)
            return TICK_W'(16);
        else if (c.len_code == 2'd0)
            return TICK_W'(24);
        else
            return TICK_W'(32);
    endfunction

endpackage

// File: rtl/framer_baud.sv
module framer_baud #(
    parameter int DIV_W      = 16,
    parameter int PRE_FACTOR = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    input  logic             pre_en,
    output logic             tick
);
    logic             pre_ok;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_lim;

    assign div_lim = (div == '0) ? '0 : div - 1'b1;

    generate
        if (PRE_FACTOR > 1) begin : g_pre
            localparam int PW = $clog2(PRE_FACTOR);
            logic [PW-1:0] pre_cnt;
            assign pre_ok = !pre_en || (pre_cnt == PW'(PRE_FACTOR - 1));
            always_ff @(posedge clk) begin
                if (rst || pre_ok)
                    pre_cnt <= '0;
                else
                    pre_cnt <= pre_cnt + 1'b1;
            end
        end else begin : g_nopre
            assign pre_ok = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            tick    <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (pre_ok) begin
                if (div_cnt >= div_lim) begin
                    div_cnt <= '0;
                    tick    <= 1'b1;
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end
        end
    end

    // R1: with an effective period above one clock, ticks never come back to back
    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && (pre_en || div > 1)) |=> !tick);

endmodule

// File: rtl/framer_tx.sv
module framer_tx
    import framer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  frame_cfg_t cfg,
    input  logic       start,
    input  logic [7:0] data,
    input  logic       brk,
    output logic       line,
    output logic       busy
);
    phase_t            st;
    logic [TICK_W-1:0] cnt;
    logic [TICK_W-1:0] last_cnt;
    logic [2:0]        idx;
    logic [7:0]        shreg;
    logic              par_q;
    logic              bit_q;
    logic              brk_q;

    assign busy     = (st != PH_IDLE);
    assign line     = bit_q & ~brk_q;
    assign last_cnt = (st == PH_STOP) ? stop_ticks(cfg) - 1'b1 : TICK_W'(OVERSAMPLE - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= PH_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            par_q <= 1'b0;
            bit_q <= 1'b1;
            brk_q <= 1'b0;
        end else begin
            brk_q <= brk;
            if (st == PH_IDLE) begin
                if (start) begin
                    st    <= PH_START;
                    cnt   <= '0;
                    idx   <= '0;
                    shreg <= data;
                    par_q <= parity_bit(data, cfg.len_code, cfg.par_odd);
                    bit_q <= 1'b0;
                end
            end else if (tick) begin
                if (cnt != last_cnt) begin
                    cnt <= cnt + 1'b1;
                end else begin
                    cnt <= '0;
                    case (st)
                        PH_START: begin
                            st    <= PH_DATA;
                            bit_q <= shreg[0];
                            shreg <= {1'b0, shreg[7:1]};
                        end
                        PH_DATA: begin
                            if (idx == last_bit_idx(cfg.len_code)) begin
                                if (cfg.par_en) begin
                                    st    <= PH_PARITY;
                                    bit_q <= par_q;
                                end else begin
                                    st    <= PH_STOP;
                                    bit_q <= 1'b1;
                                end
                            end else begin
                                idx   <= idx + 1'b1;
                                bit_q <= shreg[0];
                                shreg <= {1'b0, shreg[7:1]};
                            end
                        end
                        PH_PARITY: begin
                            st    <= PH_STOP;
                            bit_q <= 1'b1;
                        end
                        default: begin
                            st    <= PH_IDLE;
                            bit_q <= 1'b1;
                        end
                    endcase
                end
            end
        end
    end

    // R6: a requested break pulls the line low on the following clock
    a_r6_break_low: assert property (@(posedge clk) disable iff (rst)
        brk |=> !line);
    // R5: an idle transmitter accepts a start and turns busy
    a_r5_start_taken: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    // R2: an idle transmitter without break leaves the line at mark
    a_r2_idle_mark: assert property (@(posedge clk) disable iff (rst)
        (!busy && !brk_q) |-> line);

endmodule

// File: rtl/framer_rx.sv
module framer_rx
    import framer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [1:0] len_code,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       line_in,
    output logic       valid,
    output logic [7:0] data,
    output logic       perr,
    output logic       ferr,
    output logic       brk
);
    logic       s1, s2;
    phase_t     st;
    logic [3:0] cnt;
    logic [2:0] idx;
    logic [7:0] dbuf;
    logic       par_q;
    logic       zero_q;
    logic       is_break;

    assign is_break = zero_q & ~s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1     <= 1'b1;
            s2     <= 1'b1;
            st     <= PH_IDLE;
            cnt    <= '0;
            idx    <= '0;
            dbuf   <= '0;
            par_q  <= 1'b0;
            zero_q <= 1'b0;
            valid  <= 1'b0;
            data   <= '0;
            perr   <= 1'b0;
            ferr   <= 1'b0;
            brk    <= 1'b0;
        end else begin
            s1    <= line_in;
            s2    <= s1;
            valid <= 1'b0;
            case (st)
                PH_IDLE: begin
                    if (tick && !s2) begin
                        st     <= PH_START;
                        cnt    <= '0;
                        idx    <= '0;
                        dbuf   <= '0;
                        zero_q <= 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (s2)
                        st <= PH_IDLE;
                end
                default: begin
                    if (tick) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == 4'(MID_SAMPLE)) begin
                            case (st)
                                PH_START: st <= s2 ? PH_IDLE : PH_DATA;
                                PH_DATA: begin
                                    dbuf[idx] <= s2;
                                    if (s2) zero_q <= 1'b0;
                                    if (idx == last_bit_idx(len_code))
                                        st <= par_en ? PH_PARITY : PH_STOP;
                                    else
                                        idx <= idx + 1'b1;
                                end
                                PH_PARITY: begin
                                    par_q <= s2;
                                    if (s2) zero_q <= 1'b0;
                                    st <= PH_STOP;
                                end
                                default: begin
                                    valid <= 1'b1;
                                    data  <= dbuf;
                                    ferr  <= ~s2;
                                    brk   <= is_break;
                                    perr  <= par_en & ~is_break &
                                             (par_q != parity_bit(dbuf, len_code, par_odd));
                                    st    <= s2 ? PH_IDLE : PH_HOLD;
                                end
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    // R8: each delivered character is a single-cycle pulse
    a_r8_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
    // R9: a break reports a zero character with framing error and no parity error
    a_r9_break_fields: assert property (@(posedge clk) disable iff (rst)
        (valid && brk) |-> (data == 8'h00 && ferr && !perr));
    // R7: an idle receiver seeing a high line stays idle
    a_r7_idle_on_mark: assert property (@(posedge clk) disable iff (rst)
        (st == PH_IDLE && s2) |=> (st == PH_IDLE));

endmodule

// File: rtl/serial_framer.sv
module serial_framer
    import framer_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int PRE_FACTOR = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             baud_pre4,
    input  logic [1:0]       char_len,
    input  logic [1:0]       parity_mode,
    input  logic             stop_long,
    input  logic             loopback,
    input  logic             tx_start,
    input  logic [7:0]       tx_data,
    input  logic             tx_break,
    output logic             tx_busy,
    output logic             tx_line,
    input  logic             rx_line,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             rx_parity_err,
    output logic             rx_frame_err,
    output logic             rx_break
);
    frame_cfg_t cfg;
    logic       tick;
    logic       tx_int;
    logic       rx_src;

    assign cfg = '{len_code: char_len, par_en: parity_mode[1], par_odd: parity_mode[0],
                   stop_long: stop_long};

    assign tx_line = loopback ? 1'b1 : tx_int;
    assign rx_src  = loopback ? tx_int : rx_line;

    framer_baud #(.DIV_W(DIV_W), .PRE_FACTOR(PRE_FACTOR)) u_baud (
        .clk    (clk),
        .rst    (rst),
        .div    (baud_div),
        .pre_en (baud_pre4),
        .tick   (tick)
    );

    framer_tx u_tx (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .cfg   (cfg),
        .start (tx_start),
        .data  (tx_data),
        .brk   (tx_break),
        .line  (tx_int),
        .busy  (tx_busy)
    );

    framer_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .len_code (char_len),
        .par_en   (parity_mode[1]),
        .par_odd  (parity_mode[0]),
        .line_in  (rx_src),
        .valid    (rx_valid),
        .data     (rx_data),
        .perr     (rx_parity_err),
        .ferr     (rx_frame_err),
        .brk      (rx_break)
    );

    // R11: the first cycle out of reset shows an idle port
    a_r11_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tx_busy && tx_line && !rx_valid));

endmodule

// File: tb/test_serial_framer.sv
`timescale 1ns/1ps
module test_serial_framer;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst;
    logic [15:0] baud_div;
    logic        baud_pre4, stop_long, loopback, tx_start, tx_break;
    logic [1:0]  char_len, parity_mode;
    logic [7:0]  tx_data, rx_data;
    logic        tx_busy, tx_line, rx_line, rx_valid;
    logic        rx_parity_err, rx_frame_err, rx_break;
    logic        ext_loop, drv_rx;

    assign rx_line = ext_loop ? tx_line : drv_rx;

    int nchk = 0, nerr = 0, tpc = 2, got_cnt = 0;
    logic [7:0] got_data;
    logic got_pe, got_fe, got_bk;

    serial_framer i_serial_framer (
        .clk(clk), .rst(rst), .baud_div(baud_div), .baud_pre4(baud_pre4),
        .char_len(char_len), .parity_mode(parity_mode), .stop_long(stop_long),
        .loopback(loopback), .tx_start(tx_start), .tx_data(tx_data),
        .tx_break(tx_break), .tx_busy(tx_busy), .tx_line(tx_line),
        .rx_line(rx_line), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
        .rx_break(rx_break)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            got_cnt  <= got_cnt + 1;
            got_data <= rx_data;
            got_pe   <= rx_parity_err;
            got_fe   <= rx_frame_err;
            got_bk   <= rx_break;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_of(input int len);
        return 8'hFF >> (3 - len);
    endfunction

    function automatic logic exp_par(input logic [7:0] d, input int len, input logic odd);
        return (^(d & mask_of(len))) ^ odd;
    endfunction

    task automatic set_cfg(input int dv, input bit pre, input int len, input int pm, input bit sl);
        baud_div    = 16'(dv);
        baud_pre4   = pre;
        char_len    = 2'(len);
        parity_mode = 2'(pm);
        stop_long   = sl;
        tpc         = ((dv == 0) ? 1 : dv) * (pre ? 4 : 1);
        repeat (4) @(negedge clk);
    endtask

    task automatic bit_wait();
        repeat (16 * tpc) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] d);
        while (tx_busy) @(negedge clk);
        tx_data  = d;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
    endtask

    task automatic decode_tx(output logic [7:0] d, output logic p, output logic stp);
        d = 8'h00;
        p = 1'b0;
        while (tx_line !== 1'b0) @(negedge clk);
        repeat (8 * tpc) @(negedge clk);
        for (int i = 0; i < 5 + int'(char_len); i++) begin
            bit_wait();
            d[i] = tx_line;
        end
        if (parity_mode[1]) begin
            bit_wait();
            p = tx_line;
        end
        bit_wait();
        stp = tx_line;
    endtask

    task automatic drive_rx(input logic [7:0] d, input int nb, input bit pen,
                            input logic pb, input logic stopv);
        drv_rx = 1'b0;
        bit_wait();
        for (int i = 0; i < nb; i++) begin
            drv_rx = d[i];
            bit_wait();
        end
        if (pen) begin
            drv_rx = pb;
            bit_wait();
        end
        drv_rx = stopv;
        bit_wait();
        drv_rx = 1'b1;
        bit_wait();
        bit_wait();
    endtask

    task automatic wait_rx(input int base);
        int t = 0;
        while (got_cnt == base && t < 8000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic measure_high(output int n);
        n = 0;
        while (tx_line !== 1'b0) @(negedge clk);
        while (tx_line === 1'b0) @(negedge clk);
        while (tx_line === 1'b1 && tx_busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic measure_stop(output int n);
        n = 0;
        while (tx_line !== 1'b0) @(negedge clk);
        while (tx_line === 1'b0) @(negedge clk);
        while (tx_busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", nchk, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int base, n, low_seen;
        logic [7:0] dd, d, m;
        logic pp, ss;
        void'($urandom(32'h5EED));
        rst = 1'b1; baud_div = 16'd2; baud_pre4 = 1'b0; char_len = 2'd3;
        parity_mode = 2'd0; stop_long = 1'b0; loopback = 1'b0; tx_start = 1'b0;
        tx_data = 8'h00; tx_break = 1'b0; ext_loop = 1'b0; drv_rx = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(tx_line === 1'b1, "R11 tx_line", tx_line, 1);
        check(tx_busy === 1'b0, "R11 tx_busy", tx_busy, 0);
        check(rx_valid === 1'b0, "R11 rx_valid", rx_valid, 0);

        // R1 bit period: 0x55 makes data bit 0 a lone high bit of 16 ticks
        set_cfg(2, 0, 3, 0, 0);
        fork send_char(8'h55); measure_high(n); join
        check(n == 32, "R1 div2", n, 32);
        while (tx_busy) @(negedge clk);
        set_cfg(1, 1, 3, 0, 0);
        fork send_char(8'h55); measure_high(n); join
        check(n == 64, "R1 div1 pre4", n, 64);
        while (tx_busy) @(negedge clk);
        set_cfg(3, 1, 3, 0, 0);
        fork send_char(8'h55); measure_high(n); join
        check(n == 192, "R1 div3 pre4", n, 192);
        while (tx_busy) @(negedge clk);
        set_cfg(0, 0, 3, 0, 0);
        fork send_char(8'h55); measure_high(n); join
        check(n == 16, "R1 div0 acts as 1", n, 16);
        while (tx_busy) @(negedge clk);

        // R4 stop lengths, a zero character keeps the line low until stop
        set_cfg(2, 0, 0, 0, 0);
        fork send_char(8'h00); measure_stop(n); join
        check(n == 32, "R4 5-bit short stop", n, 32);
        set_cfg(2, 0, 0, 0, 1);
        fork send_char(8'h00); measure_stop(n); join
        check(n == 48, "R4 5-bit 1.5 stop", n, 48);
        set_cfg(2, 0, 3, 0, 1);
        fork send_char(8'h00); measure_stop(n); join
        check(n == 64, "R4 8-bit 2 stop", n, 64);

        // R5 start while busy is ignored
        set_cfg(2, 0, 3, 0, 0);
        fork
            decode_tx(dd, pp, ss);
            begin
                send_char(8'h3C);
                repeat (50) @(negedge clk);
                tx_data = 8'hFF; tx_start = 1'b1;
                @(negedge clk);
                tx_start = 1'b0;
            end
        join
        check(dd == 8'h3C, "R5 frame kept", dd, 8'h3C);
        while (tx_busy) @(negedge clk);
        n = 0;
        repeat (400) begin
            @(negedge clk);
            if (tx_busy || !tx_line) n++;
        end
        check(n == 0, "R5 no follow-up frame", n, 0);

        // R7 false start, then a valid frame
        base = got_cnt;
        drv_rx = 1'b0;
        repeat (4 * tpc) @(negedge clk);
        drv_rx = 1'b1;
        repeat (16 * tpc * 12) @(negedge clk);
        check(got_cnt == base, "R7 false start dropped", got_cnt - base, 0);
        drive_rx(8'hA5, 8, 0, 1'b0, 1'b1);
        check(got_cnt == base + 1 && got_data == 8'hA5 && !got_fe && !got_pe,
              "R7 good frame after glitch", got_data, 8'hA5);

        // R8 framing error
        base = got_cnt;
        drive_rx(8'h5A, 8, 0, 1'b0, 1'b0);
        check(got_cnt == base + 1, "R8 one char", got_cnt - base, 1);
        check(got_fe && !got_bk && got_data == 8'h5A, "R8 framing flag",
              {got_fe, got_bk, got_data}, {2'b10, 8'h5A});

        // R3 parity error (even) and clean odd parity
        set_cfg(2, 0, 3, 2, 0);
        base = got_cnt;
        drive_rx(8'h33, 8, 1, ~exp_par(8'h33, 3, 1'b0), 1'b1);
        check(got_cnt == base + 1 && got_pe && !got_fe, "R3 even parity error",
              got_pe, 1);
        set_cfg(2, 0, 3, 3, 0);
        base = got_cnt;
        drive_rx(8'h33, 8, 1, exp_par(8'h33, 3, 1'b1), 1'b1);
        check(got_cnt == base + 1 && !got_pe && got_data == 8'h33, "R3 odd parity ok",
              got_pe, 0);

        // R6 and R9 break generation and detection over the external loop
        set_cfg(2, 0, 3, 2, 0);
        ext_loop = 1'b1;
        repeat (10) @(negedge clk);
        base = got_cnt;
        tx_break = 1'b1;
        @(negedge clk);
        check(tx_line === 1'b0, "R6 break drives low", tx_line, 0);
        repeat (16 * tpc * 13) @(negedge clk);
        check(got_cnt == base + 1, "R9 one break char", got_cnt - base, 1);
        check(got_bk && got_fe && !got_pe && got_data == 8'h00, "R9 break fields",
              {got_bk, got_fe, got_pe, got_data}, {3'b110, 8'h00});
        repeat (16 * tpc * 13) @(negedge clk);
        check(got_cnt == base + 1, "R9 held until mark", got_cnt - base, 1);
        tx_break = 1'b0;
        repeat (40) @(negedge clk);
        base = got_cnt;
        send_char(8'h81);
        wait_rx(base);
        check(got_cnt == base + 1 && got_data == 8'h81 && !got_bk, "R9 recovery",
              got_data, 8'h81);
        while (tx_busy) @(negedge clk);

        // R10 loopback ignores rx_line and keeps tx_line high
        ext_loop = 1'b0;
        drv_rx   = 1'b1;
        loopback = 1'b1;
        repeat (5) @(negedge clk);
        drv_rx = 1'b0;
        set_cfg(2, 0, 3, 0, 0);
        base = got_cnt;
        low_seen = 0;
        fork
            send_char(8'h96);
            repeat (16 * tpc * 12) begin
                @(negedge clk);
                if (tx_line !== 1'b1) low_seen++;
            end
        join
        check(low_seen == 0, "R10 tx_line held high", low_seen, 0);
        check(got_cnt == base + 1 && got_data == 8'h96 && !got_fe, "R10 internal path",
              got_data, 8'h96);
        drv_rx = 1'b1;
        repeat (5) @(negedge clk);
        loopback = 1'b0;

        // R2 R3 R4 R8 random frames over the external loop
        ext_loop = 1'b1;
        for (int it = 0; it < 40; it++) begin
            int dv, len, pm;
            bit pre, sl;
            dv  = int'($urandom_range(1, 2));
            pre = (dv == 1) ? bit'($urandom_range(0, 1)) : 1'b0;
            len = int'($urandom_range(0, 3));
            pm  = int'($urandom_range(0, 3));
            sl  = bit'($urandom_range(0, 1));
            set_cfg(dv, pre, len, pm, sl);
            d = 8'($urandom);
            m = mask_of(len);
            base = got_cnt;
            fork send_char(d); decode_tx(dd, pp, ss); join
            wait_rx(base);
            while (tx_busy) @(negedge clk);
            check(dd == (d & m), "R2 line data lsb first", dd, d & m);
            if (pm >= 2)
                check(pp == exp_par(d, len, pm[0]), "R3 parity bit", pp,
                      exp_par(d, len, pm[0]));
            check(ss == 1'b1, "R4 stop level", ss, 1);
            check(got_cnt == base + 1 && got_data == (d & m) && !got_pe && !got_fe && !got_bk,
                  "R8 received char", got_data, d & m);
        end

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule